// File: doc/BRIEF.md
# Comparator output conditioning and interrupt logic

This block is the digital path that sits behind an analog voltage comparator. It takes the raw compare result as an asynchronous one-bit input and brings it into the clock domain through a two-flop synchronizer. It can then invert the result to account for swapped comparator inputs and pass it through a settle filter with a selectable delay. Last, it applies an output polarity. The conditioned bit drives the visible output and a hysteresis reference-select line, and it raises two sticky interrupt flags that respond to opposite edges.

Software configures the path with a 16-bit control word written over a simple strobe-and-data bus. Only bits 12 to 1 are stored. The flags are cleared through separate write-one-to-clear strobes. The analog comparator, the reference ladder, the power modes themselves and interrupt vectoring are all outside this block.

Top module: `cmp_cond_path`

## Requirements
- R1: Readback `reg_rdata` has bits 15:13 always 0 and bit 0 equal to `cmp_out`. Bits 12:1 return the last value written. Writes to bits 15:13 and bit 0 are ignored.
- R2: While the enable bit (bit 10) is 0, `cmp_out` is 0, the filter is cleared and no flag is set.
- R3: With the filter inactive and the path enabled, a change on `cmp_raw` made between clock edges appears on `cmp_out` after the third rising edge and not earlier.
- R4: Bit 5 (exchange) inverts the output and drives `in_swap`. Bit 4 (short) drives `in_short`.
- R5: Bit 1 (polarity) inverts `cmp_out` after the exchange and filter stages.
- R6: The filter works only when bit 2 is 1 and the power mode (bits 9:8) is 00 or 01. When it works, a held change reaches `cmp_out` after 2 + FILT_BASE·2^d rising edges, where d is bits 7:6. With power mode 10, the path is unfiltered.
- R7: With the filter active, an input pulse shorter than the selected settle count leaves `cmp_out` unchanged and sets no flag.
- R8: With bit 3 (edge select) at 0, `flag_main` sets on a rising `cmp_out` edge and `flag_inv` on a falling one. With bit 3 at 1, the two edges swap.
- R9: Changing bit 3 sets `flag_main` when the change makes `cmp_out` XOR bit 3 rise.
- R10: Each flag stays set until its clear strobe is pulsed. A set event and a clear in the same cycle leave the flag set.
- R11: When `rsrc_mode` is not 11, `ref_sel` follows `cmp_out` if bit 12 is 0 and follows bit 11 if bit 12 is 1. When `rsrc_mode` is 11, `ref_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_raw | input | 1 | Asynchronous raw comparator result |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write data |
| reg_rdata | output | 16 | Control word readback with the output in bit 0 |
| clr_main | input | 1 | Write-one-to-clear strobe for flag_main |
| clr_inv | input | 1 | Write-one-to-clear strobe for flag_inv |
| rsrc_mode | input | 2 | Resistor-source mode from the reference block |
| cmp_out | output | 1 | Conditioned comparator output |
| flag_main | output | 1 | Main edge interrupt flag |
| flag_inv | output | 1 | Opposite-edge interrupt flag |
| in_swap | output | 1 | Input-exchange control to the analog side |
| in_short | output | 1 | Input-short control to the analog side |
| ref_sel | output | 1 | Reference 0/1 select |

## Verification
The hardest case to reach is a flag set and its clear strobe landing in the same cycle. The set arrives only after the synchronizer, the filter register and the edge register. The bench therefore changes the raw input, counts three falling edges and raises the clear strobe for exactly the cycle in which the set is registered. The sub-threshold pulse case is reached the same way: the raw input is held for one cycle fewer than the settle count, so the filter sees the difference on exactly that many edges and never commits it.

// File: rtl/cmp_pkg.sv
// Shared types for the comparator conditioning path.
// Assumes the stored control field order matches control word bits 12..1.
package cmp_pkg;
    typedef struct packed {
        logic       ref_sw;     // bit 12: software drives reference select
        logic       ref_lvl;    // bit 11: software reference level
        logic       enable;     // bit 10
        logic [1:0] pwr;        // bits 9:8
        logic [1:0] dly;        // bits 7:6
        logic       exch;       // bit 5
        logic       shrt;       // bit 4
        logic       edge_sel;   // bit 3
        logic       filt_en;    // bit 2
        logic       pol;        // bit 1
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/cmp_sync.sv
// Multi-stage synchronizer for the asynchronous comparator result.
// Assumes the input is level-like and may change at any time.
module cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/cmp_filter.sv
// Settle filter: commits a new level only after the input has differed from
// the held level for BASE<<dly consecutive clocks. When inactive, it follows
// the input with one register of delay. Cleared while the path is disabled.
module cmp_filter #(
    parameter int BASE = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       active,
    input  logic [1:0] dly,
    input  logic       din,
    output logic       dout
);
    localparam int MAXC  = BASE * 8;
    localparam int CNT_W = $clog2(MAXC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;
    logic             lvl_q;

    // Selected settle count (doubles per delay step).
    always_comb lim = CNT_W'(BASE) << dly;

    // Count consecutive differing cycles and commit at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
            lvl_q <= 1'b0;
        end else if (!active) begin
            cnt_q <= '0;
            lvl_q <= din;
        end else if (din == lvl_q) begin
            cnt_q <= '0;
        end else if (cnt_q == lim - 1'b1) begin
            cnt_q <= '0;
            lvl_q <= din;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign dout = lvl_q;

    // R6
    filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && active && (din != lvl_q) && (cnt_q != lim - 1'b1)) |=> $stable(lvl_q));

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q < lim) || (cnt_q == '0));
endmodule

// File: rtl/cmp_edge_flags.sv
// Two sticky interrupt flags on opposite edges of (level XOR edge_sel).
// A change of edge_sel is thus seen as an edge. A set event wins over a clear.
// Assumes level is 0 whenever en is 0.
module cmp_edge_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic level,
    input  logic edge_sel,
    input  logic clr_main,
    input  logic clr_inv,
    output logic flag_main,
    output logic flag_inv
);
    logic trig, trig_q, set_main, set_inv;

    // Trigger level and its edges.
    always_comb begin
        trig     = level ^ edge_sel;
        set_main = en &  trig & ~trig_q;
        set_inv  = en & ~trig &  trig_q;
    end

    // Remember the trigger level and keep the flags sticky.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q    <= 1'b0;
            flag_main <= 1'b0;
            flag_inv  <= 1'b0;
        end else begin
            trig_q    <= trig;
            flag_main <= (flag_main & ~clr_main) | set_main;
            flag_inv  <= (flag_inv  & ~clr_inv)  | set_inv;
        end
    end

    // R2
    off_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !flag_main && !flag_inv) |=> (!flag_main && !flag_inv));

    // R10
    sticky_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_main && !clr_main) |=> flag_main);

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_main || set_inv) |=> (flag_main || flag_inv));
endmodule

// File: rtl/cmp_cond_path.sv
// Top of the comparator conditioning path: control register, synchronizer,
// exchange, settle filter, polarity, reference select and edge flags.
// Assumes cmp_raw is asynchronous and reg_wr is a single-cycle strobe.
module cmp_cond_path #(
    parameter int FILT_BASE   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmp_raw,
    input  logic        reg_wr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        clr_main,
    input  logic        clr_inv,
    input  logic [1:0]  rsrc_mode,
    output logic        cmp_out,
    output logic        flag_main,
    output logic        flag_inv,
    output logic        in_swap,
    output logic        in_short,
    output logic        ref_sel
);
    import cmp_pkg::*;

    ctrl_t ctrl_q;
    logic  sync_lvl, exch_lvl, filt_lvl, filt_active;
    logic  unused_wbits;

    assign unused_wbits = ^{reg_wdata[15:13], reg_wdata[0]};

    // Hold the writable control fields.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl_q <= '0;
        else if (reg_wr) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W:1]);
    end

    cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(cmp_raw), .dout(sync_lvl)
    );

    // Exchange inversion and filter gating by power mode.
    always_comb begin
        exch_lvl    = sync_lvl ^ ctrl_q.exch;
        filt_active = ctrl_q.filt_en & ~ctrl_q.pwr[1];
    end

    cmp_filter #(.BASE(FILT_BASE)) u_filt (
        .clk(clk), .rst_n(rst_n), .en(ctrl_q.enable), .active(filt_active),
        .dly(ctrl_q.dly), .din(exch_lvl), .dout(filt_lvl)
    );

    // Output polarity, analog controls, reference select and readback.
    always_comb begin
        cmp_out   = ctrl_q.enable & (filt_lvl ^ ctrl_q.pol);
        in_swap   = ctrl_q.exch;
        in_short  = ctrl_q.shrt;
        ref_sel   = (rsrc_mode == 2'b11) ? 1'b0
                  : (ctrl_q.ref_sw ? ctrl_q.ref_lvl : cmp_out);
        reg_rdata = {3'b000, ctrl_q, cmp_out};
    end

    cmp_edge_flags u_flags (
        .clk(clk), .rst_n(rst_n), .en(ctrl_q.enable), .level(cmp_out),
        .edge_sel(ctrl_q.edge_sel), .clr_main(clr_main), .clr_inv(clr_inv),
        .flag_main(flag_main), .flag_inv(flag_inv)
    );

    // R1
    rd_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[0] == cmp_out) && (reg_rdata[15:13] == 3'b000));
endmodule

// File: tb/cmp_cond_path_test.sv
// Directed bench for cmp_cond_path: one task per scenario.
module cmp_cond_path_test;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;

    localparam logic [15:0] B_EN = 16'h0400, B_EX = 16'h0020, B_SH = 16'h0010,
                            B_IES = 16'h0008, B_FEN = 16'h0004, B_POL = 16'h0002,
                            B_MRVS = 16'h1000, B_MRVL = 16'h0800;

    logic clk = 0, rst_n = 0, cmp_raw = 0, reg_wr = 0, clr_main = 0, clr_inv = 0;
    logic [15:0] reg_wdata = 0;
    logic [15:0] reg_rdata;
    logic [1:0]  rsrc_mode = 0;
    logic cmp_out, flag_main, flag_inv, in_swap, in_short, ref_sel;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_cond_path #(.FILT_BASE(NB)) uut (
        .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clr_main(clr_main),
        .clr_inv(clr_inv), .rsrc_mode(rsrc_mode), .cmp_out(cmp_out),
        .flag_main(flag_main), .flag_inv(flag_inv), .in_swap(in_swap),
        .in_short(in_short), .ref_sel(ref_sel)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] v);
        @(negedge clk); reg_wr = 1; reg_wdata = v;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic raw(input logic v);
        @(negedge clk); cmp_raw = v;
    endtask

    task automatic clr_all();
        @(negedge clk); clr_main = 1; clr_inv = 1;
        @(negedge clk); clr_main = 0; clr_inv = 0;
    endtask

    task automatic t_reset();
        chk("R1 reset rdata", reg_rdata, 16'h0000);
        chk("R2 reset out/flags", {13'd0, cmp_out, flag_main, flag_inv}, 16'h0);
    endtask

    task automatic t_readback();
        wr(16'hE001);
        chk("R1 reserved+bit0 ignored", reg_rdata, 16'h0000);
        wr(16'hFFFE & ~B_EN);
        chk("R1 rw bits", reg_rdata, 16'h1BFE);
        wr(16'h0000);
    endtask

    task automatic t_disable();
        raw(1); cyc(8);
        chk("R2 off out", {15'd0, cmp_out}, 16'h0);
        chk("R2 off flags", {14'd0, flag_main, flag_inv}, 16'h0);
        raw(0); cyc(4);
    endtask

    task automatic t_unfilt();
        wr(B_EN); cyc(4); clr_all();
        raw(1); cyc(2);
        chk("R3 not yet", {15'd0, cmp_out}, 16'h0);
        cyc(1);
        chk("R3 out after 3", {15'd0, cmp_out}, 16'h1);
        chk("R1 bit0 mirror", {15'd0, reg_rdata[0]}, 16'h1);
        cyc(2);
        chk("R8 rise main", {14'd0, flag_main, flag_inv}, 16'h2);
        raw(0); cyc(5);
        chk("R8 fall inv", {14'd0, flag_main, flag_inv}, 16'h3);
        clr_all();
    endtask

    task automatic t_polex();
        raw(1); cyc(4);
        wr(B_EN | B_POL);
        chk("R5 polarity", {15'd0, cmp_out}, 16'h0);
        wr(B_EN | B_EX); cyc(4);
        chk("R4 exchange", {14'd0, cmp_out, in_swap}, 16'h1);
        wr(B_EN | B_SH);
        chk("R4 short", {14'd0, in_short, in_swap}, 16'h2);
        raw(0); cyc(4); clr_all();
    endtask

    task automatic t_filter();
        for (int d = 0; d < 4; d++) begin
            int lim;
            lim = NB << d;
            wr(B_EN | B_FEN | 16'(d << 6)); cyc(lim + 4);
            raw(1); cyc(lim + 1);
            chk("R6 filt hold", {15'd0, cmp_out}, 16'h0);
            cyc(1);
            chk("R6 filt commit", {15'd0, cmp_out}, 16'h1);
            raw(0); cyc(lim + 1);
            chk("R6 filt hold fall", {15'd0, cmp_out}, 16'h1);
            cyc(1);
            chk("R6 filt commit fall", {15'd0, cmp_out}, 16'h0);
        end
        wr(B_EN | B_FEN | 16'h0200 | 16'h00C0); cyc(4);
        raw(1); cyc(3);
        chk("R6 ulp unfiltered", {15'd0, cmp_out}, 16'h1);
        raw(0); cyc(4); clr_all();
    endtask

    task automatic t_glitch();
        wr(B_EN | B_FEN); cyc(8); clr_all();
        raw(1); cyc(NB - 2);
        raw(0); cyc(10);
        chk("R7 pulse rejected", {13'd0, cmp_out, flag_main, flag_inv}, 16'h0);
    endtask

    task automatic t_edges();
        wr(B_EN | B_IES); clr_all();
        raw(1); cyc(5);
        chk("R8 ies1 rise -> inv", {14'd0, flag_main, flag_inv}, 16'h1);
        clr_all();
        raw(0); cyc(5);
        chk("R8 ies1 fall -> main", {14'd0, flag_main, flag_inv}, 16'h2);
        clr_all();
    endtask

    task automatic t_ies_change();
        wr(B_EN); cyc(2); clr_all();
        wr(B_EN | B_IES); cyc(1);
        chk("R9 ies change sets main", {14'd0, flag_main, flag_inv}, 16'h2);
        clr_all();
    endtask

    task automatic t_clear();
        wr(B_EN); cyc(4); clr_all();
        raw(1); cyc(3);
        clr_main = 1; @(negedge clk); clr_main = 0;
        chk("R10 set wins over clear", {15'd0, flag_main}, 16'h1);
        cyc(3);
        chk("R10 sticky", {15'd0, flag_main}, 16'h1);
        clr_main = 1; @(negedge clk); clr_main = 0;
        chk("R10 cleared", {15'd0, flag_main}, 16'h0);
    endtask

    task automatic t_ref();
        chk("R11 follows out", {14'd0, cmp_out, ref_sel}, 16'h3);
        wr(B_EN | B_MRVS);
        chk("R11 sw level 0", {15'd0, ref_sel}, 16'h0);
        wr(B_EN | B_MRVS | B_MRVL); raw(0); cyc(4);
        chk("R11 sw level 1", {15'd0, ref_sel}, 16'h1);
        rsrc_mode = 2'b11; #1;
        chk("R11 mode 11", {15'd0, ref_sel}, 16'h0);
        rsrc_mode = 2'b00;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        cyc(3); rst_n = 1; cyc(1);
        t_reset();
        t_readback();
        t_disable();
        t_unfilt();
        t_polex();
        t_filter();
        t_glitch();
        t_edges();
        t_ies_change();
        t_clear();
        t_ref();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule